// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Noise Voting

This block receives asynchronous serial bytes. The line is sampled on a tick that runs at sixteen times the bit rate. After a falling edge on the idle line, a candidate start bit is qualified by two three-sample votes. Each data bit and the stop bit is then recovered as the majority of three samples taken near the middle of its bit cell. When any vote sees samples that disagree, the frame is still delivered, but a sticky noise flag is raised together with the data-ready flag. A stop bit that votes low raises a framing-error flag.

Software polls or takes the interrupt. It reads the status, then the data. Only that ordered pair clears the error flags. A data read on its own releases only the data-ready flag. The serial input is resynchronised by a two-flop chain before it is sampled. The receiver works only while its enable is high.

The controller has four states. IDLE waits for a falling edge on a tick while enabled (IDLE→START). START counts ticks and collects the start votes. It goes back to IDLE on a rejected start (START→IDLE), and enters DATA after a full accepted cell (START→DATA). DATA loops once per data bit and enters STOP after the last bit (DATA→STOP). STOP delivers the byte at the stop bit's middle vote (STOP→IDLE). A low enable forces any state to IDLE (any→IDLE).

Top module: `uart_os_rx`

## Requirements
- R1: While reset is held, rx_data is 0 and data_ready, noise_err, frame_err and irq are 0.
- R2: A falling edge starts a frame only while rx_en is 1. Dropping rx_en during a frame discards it: rx_data and all flags stay unchanged.
- R3: Ticks are numbered from 1, where tick 1 is the tick that sees the line fall. Group A is the samples at ticks 3, 5 and 7. Group B is the samples at ticks 8, 9 and 10. If either group holds two or more 1s, the start is rejected and the receiver returns to waiting for a new falling edge. If both groups are 000, the start is accepted clean. Any other case is accepted and marks the frame noisy.
- R4: A frame is one start bit, 8 data bits sent least significant bit first, and one stop bit, each 16 ticks long. Each data bit is the majority of its samples at cell ticks 7, 8 and 9.
- R5: A mixed vote (neither 000 nor 111) in the start, data or stop bits sets noise_err. It is set in the same clock as data_ready, and the majority byte is still delivered.
- R6: rx_data and data_ready update on the clock edge of the stop bit's tick 9. data_ready stays 1 until a data_rd pulse.
- R7: noise_err and frame_err are sticky. They clear only on a data_rd that follows a stat_rd in an earlier clock with no data_rd in between. A data_rd alone leaves them set.
- R8: A stop bit whose ticks 7, 8 and 9 vote 0 sets frame_err together with data_ready.
- R9: irq is 1 exactly when data_ready and rx_ie are both 1. noise_err or frame_err alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_ie | input | 1 | Receive interrupt enable |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Last received byte |
| data_ready | output | 1 | A byte is waiting to be read |
| noise_err | output | 1 | Sticky noise flag |
| frame_err | output | 1 | Sticky framing-error flag |
| irq | output | 1 | Receive interrupt request |

## Verification
A level on serial_in reaches the sampling point after two clocks. The bench therefore changes the line three clocks before each tick, and each tick samples the level chosen for it. The byte and its flags are due on the clock edge of the stop bit's tick 9, and a read strobe takes effect on the edge where it is high. The bench updates its expected state right after the same edges and compares every output on each falling clock edge. Noise patterns are placed on chosen ticks of chosen cells. This covers single mixed samples, majority overturns, each start-group case and rejected starts.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    // val: vote result, mixed: the samples disagreed
    typedef struct packed {
        logic val;
        logic mixed;
    } vote_t;

    function automatic vote_t vote3(input logic [2:0] s);
        vote_t r;
        r.val   = (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
        r.mixed = (|s) & ~(&s);
        return r;
    endfunction

    // val: start accepted, mixed: accepted with a stray high sample
    function automatic vote_t start_vote(input logic [2:0] a, input logic [2:0] b);
        vote_t r;
        r.val   = ~vote3(a).val & ~vote3(b).val;
        r.mixed = |{a, b};
        return r;
    endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_flags.sv
module uart_os_rx_flags #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 load_noise,
    input  logic                 load_ferr,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    input  logic                 rx_ie,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 noise_err,
    output logic                 frame_err,
    output logic                 irq
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            noise_err  <= 1'b0;
            frame_err  <= 1'b0;
            armed      <= 1'b0;
        end else begin
            if (load) begin
                rx_data    <= load_data;
                data_ready <= 1'b1;
                noise_err  <= noise_err | load_noise;
                frame_err  <= frame_err | load_ferr;
            end else if (data_rd) begin
                data_ready <= 1'b0;
                if (armed) begin
                    noise_err <= 1'b0;
                    frame_err <= 1'b0;
                end
            end
            if (data_rd)      armed <= 1'b0;
            else if (stat_rd) armed <= 1'b1;
        end
    end

    assign irq = data_ready & rx_ie;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 rx_ie,
    input  logic                 os_tick,
    input  logic                 serial_in,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 noise_err,
    output logic                 frame_err,
    output logic                 irq
);
    localparam int CNT_W = $clog2(OVS + 1);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID   = OVS / 2;
    localparam logic [CNT_W-1:0] S_A0 = CNT_W'(MID - 5);
    localparam logic [CNT_W-1:0] S_A1 = CNT_W'(MID - 3);
    localparam logic [CNT_W-1:0] S_A2 = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] S_B0 = CNT_W'(MID);
    localparam logic [CNT_W-1:0] S_B1 = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] S_B2 = CNT_W'(MID + 2);
    localparam logic [CNT_W-1:0] S_M0 = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] S_M1 = CNT_W'(MID);
    localparam logic [CNT_W-1:0] S_M2 = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    logic line_s, line_prev;

    rx_state_e state, nxt_state;
    logic [CNT_W-1:0]     cnt, nxt_cnt, pos;
    logic [IDX_W-1:0]     idx, nxt_idx;
    logic [DATA_BITS-1:0] shreg, nxt_shreg;
    logic [2:0]           grp_a, nxt_grp_a;
    logic [1:0]           grp_b, nxt_grp_b;
    logic [1:0]           win, nxt_win;
    logic                 fr_noise, nxt_noise;
    logic                 load, load_noise, load_ferr;
    vote_t                bit_v, st_v;

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (serial_in),
        .dout (line_s)
    );

    // next-state process
    always_comb begin
        nxt_state  = state;
        nxt_cnt    = cnt;
        nxt_idx    = idx;
        nxt_shreg  = shreg;
        nxt_grp_a  = grp_a;
        nxt_grp_b  = grp_b;
        nxt_win    = win;
        nxt_noise  = fr_noise;
        load       = 1'b0;
        load_noise = 1'b0;
        load_ferr  = 1'b0;
        pos        = cnt + 1'b1;
        bit_v      = vote3({win, line_s});
        st_v       = start_vote(grp_a, {grp_b, line_s});
        if (!rx_en) begin
            nxt_state = ST_IDLE;
            nxt_cnt   = '0;
        end else if (os_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (line_prev && !line_s) begin
                        nxt_state = ST_START;
                        nxt_cnt   = CNT_W'(1);
                        nxt_noise = 1'b0;
                    end
                end
                ST_START: begin
                    nxt_cnt = pos;
                    if (pos == S_A0 || pos == S_A1 || pos == S_A2)
                        nxt_grp_a = {grp_a[1:0], line_s};
                    if (pos == S_B0 || pos == S_B1)
                        nxt_grp_b = {grp_b[0], line_s};
                    if (pos == S_B2) begin
                        nxt_noise = st_v.mixed;
                        if (!st_v.val) begin
                            nxt_state = ST_IDLE;
                            nxt_cnt   = '0;
                        end
                    end
                    if (pos == LAST) begin
                        nxt_state = ST_DATA;
                        nxt_cnt   = '0;
                        nxt_idx   = '0;
                    end
                end
                ST_DATA: begin
                    nxt_cnt = pos;
                    if (pos == S_M0 || pos == S_M1)
                        nxt_win = {win[0], line_s};
                    if (pos == S_M2) begin
                        nxt_shreg = {bit_v.val, shreg[DATA_BITS-1:1]};
                        nxt_noise = fr_noise | bit_v.mixed;
                    end
                    if (pos == LAST) begin
                        nxt_cnt = '0;
                        if (idx == IDX_LAST) nxt_state = ST_STOP;
                        else                 nxt_idx   = idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    nxt_cnt = pos;
                    if (pos == S_M0 || pos == S_M1)
                        nxt_win = {win[0], line_s};
                    if (pos == S_M2) begin
                        load       = 1'b1;
                        load_noise = fr_noise | bit_v.mixed;
                        load_ferr  = ~bit_v.val;
                        nxt_state  = ST_IDLE;
                        nxt_cnt    = '0;
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            grp_a     <= '0;
            grp_b     <= '0;
            win       <= '0;
            fr_noise  <= 1'b0;
            line_prev <= 1'b1;
        end else begin
            state    <= nxt_state;
            cnt      <= nxt_cnt;
            idx      <= nxt_idx;
            shreg    <= nxt_shreg;
            grp_a    <= nxt_grp_a;
            grp_b    <= nxt_grp_b;
            win      <= nxt_win;
            fr_noise <= nxt_noise;
            if (os_tick) line_prev <= line_s;
        end
    end

    // output process lives in the flag register block
    uart_os_rx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (shreg),
        .load_noise(load_noise),
        .load_ferr (load_ferr),
        .stat_rd   (stat_rd),
        .data_rd   (data_rd),
        .rx_ie     (rx_ie),
        .rx_data   (rx_data),
        .data_ready(data_ready),
        .noise_err (noise_err),
        .frame_err (frame_err),
        .irq       (irq)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic data_rd,
    input logic data_ready,
    input logic noise_err,
    input logic frame_err,
    input logic irq
);
    AST_LOAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_en)); // R2

    AST_NOISE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_err) |-> data_ready); // R5

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !data_rd) |=> data_ready); // R6

    AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_err && !data_rd) |=> noise_err); // R7

    AST_FERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> data_ready); // R8

    AST_NO_FLAG_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((noise_err || frame_err) && !data_ready) |-> !irq); // R9
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .data_rd   (data_rd),
    .data_ready(data_ready),
    .noise_err (noise_err),
    .frame_err (frame_err),
    .irq       (irq)
);

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, rx_en = 1'b0, rx_ie = 1'b0, os_tick = 1'b0;
    logic serial_in = 1'b1, stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_data;
    logic data_ready, noise_err, frame_err, irq;

    uart_os_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_ie(rx_ie), .os_tick(os_tick),
        .serial_in(serial_in), .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_data(rx_data), .data_ready(data_ready), .noise_err(noise_err),
        .frame_err(frame_err), .irq(irq)
    );

    int checks = 0, failures = 0;
    bit run_cmp = 0, done = 0;
    logic [7:0] e_data = '0;
    bit e_ready = 0, e_noise = 0, e_frame = 0, armed = 0;
    logic [15:0] flip [0:9];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-clock comparison against the behavioural model
    always @(negedge clk) if (run_cmp) begin
        chk(rx_data == e_data, "R4 rx_data", rx_data, e_data);
        chk(data_ready == e_ready, "R6 data_ready", data_ready, e_ready);
        chk(noise_err == e_noise, "R5 noise_err", noise_err, e_noise);
        chk(frame_err == e_frame, "R8 frame_err", frame_err, e_frame);
        chk(irq == (e_ready && rx_ie), "R9 irq", irq, e_ready && rx_ie);
    end

    task automatic clear_flips();
        for (int c = 0; c < 10; c++) flip[c] = '0;
    endtask

    // one oversample tick; returns just after the sampling edge
    task automatic tick_sample(input bit v);
        @(negedge clk); os_tick = 1'b0; serial_in = v;
        @(negedge clk);
        @(negedge clk); os_tick = 1'b1;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick_sample(1'b1);
    endtask

    task automatic rd(input bit s, input bit d);
        @(negedge clk); os_tick = 1'b0; stat_rd = s; data_rd = d;
        @(posedge clk);
        if (d) begin
            e_ready = 0;
            if (armed) begin e_noise = 0; e_frame = 0; end
            armed = 0;
        end else if (s) armed = 1;
        @(negedge clk); stat_rd = 1'b0; data_rd = 1'b0;
    endtask

    function automatic bit samp(input int c, input int k, input logic [7:0] d, input bit sv);
        bit base;
        base = (c == 0) ? 1'b0 : (c == 9) ? sv : d[c-1];
        return base ^ flip[c][k-1];
    endfunction

    // abort_cell >= 0 drops rx_en from tick 1 of that cell to the frame end
    task automatic send_frame(input logic [7:0] d, input bit sv, input int abort_cell);
        int a, b, n;
        bit acc, nz, fe;
        logic [7:0] got;
        a = samp(0,3,d,sv) + samp(0,5,d,sv) + samp(0,7,d,sv);
        b = samp(0,8,d,sv) + samp(0,9,d,sv) + samp(0,10,d,sv);
        acc = (a <= 1) && (b <= 1);
        nz  = (a == 1) || (b == 1);
        for (int i = 0; i < 8; i++) begin
            n = samp(i+1,7,d,sv) + samp(i+1,8,d,sv) + samp(i+1,9,d,sv);
            got[i] = (n >= 2);
            if (n == 1 || n == 2) nz = 1;
        end
        n  = samp(9,7,d,sv) + samp(9,8,d,sv) + samp(9,9,d,sv);
        fe = (n < 2);
        if (n == 1 || n == 2) nz = 1;
        for (int c = 0; c < 10; c++)
            for (int k = 1; k <= 16; k++) begin
                if (c == abort_cell && k == 1) rx_en = 1'b0;
                tick_sample(samp(c, k, d, sv));
                if (c == 9 && k == 9 && acc && abort_cell < 0) begin
                    e_data = got; e_ready = 1; e_noise |= nz; e_frame |= fe;
                end
            end
        rx_en = 1'b1;
        idle(4);
    endtask

    // low_mask bit k-1 = 1 drives the line low on tick k
    task automatic glitch(input logic [15:0] low_mask);
        for (int k = 1; k <= 16; k++) tick_sample(!low_mask[k-1]);
        idle(40);
    endtask

    task automatic clear_all();
        rd(1, 0); rd(0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_flips();
        repeat (3) @(negedge clk);
        chk(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);
        chk({data_ready, noise_err, frame_err, irq} == 4'b0, "R1 reset flags",
            {data_ready, noise_err, frame_err, irq}, 0);
        rst_n = 1'b1; rx_en = 1'b1; rx_ie = 1'b1;
        run_cmp = 1;
        idle(4);

        // clean frame
        send_frame(8'hA5, 1'b1, -1);
        chk(rx_data == 8'hA5 && data_ready, "R4 clean byte", rx_data, 8'hA5);
        chk(noise_err == 0, "R5 clean frame no noise", noise_err, 0);
        chk(irq == 1, "R9 irq with ready", irq, 1);
        rd(0, 1);
        chk(data_ready == 0, "R6 ready released by data read", data_ready, 0);

        // single stray sample: noisy, byte intact
        flip[3][7] = 1'b1;
        send_frame(8'h3C, 1'b1, -1);
        chk(rx_data == 8'h3C, "R5 noisy byte still delivered", rx_data, 8'h3C);
        chk(noise_err == 1 && data_ready == 1, "R5 noise with ready", noise_err, 1);
        rd(0, 1);

        // two of three samples flipped: majority overturns bit 5
        clear_flips();
        flip[6][6] = 1'b1; flip[6][8] = 1'b1;
        send_frame(8'h3C, 1'b1, -1);
        chk(rx_data == 8'h1C, "R4 majority vote", rx_data, 8'h1C);
        rd(0, 1);
        chk(noise_err == 1, "R7 data read alone keeps noise", noise_err, 1);
        clear_all();
        chk(noise_err == 0, "R7 status then data read clears noise", noise_err, 0);

        // start: one high sample in group A
        clear_flips();
        flip[0][4] = 1'b1;
        send_frame(8'h5A, 1'b1, -1);
        chk(data_ready && rx_data == 8'h5A && noise_err, "R3 group A single one accepted noisy", rx_data, 8'h5A);
        clear_all();

        // start: one high sample in each group
        clear_flips();
        flip[0][2] = 1'b1; flip[0][8] = 1'b1;
        send_frame(8'hC3, 1'b1, -1);
        chk(data_ready && rx_data == 8'hC3 && noise_err, "R3 one per group accepted noisy", rx_data, 8'hC3);
        clear_all();
        clear_flips();

        // rejected starts
        glitch(16'h0003);
        glitch(16'h007F);
        glitch(16'hFFEB);
        chk(data_ready == 0, "R3 rejected starts deliver nothing", data_ready, 0);
        send_frame(8'h81, 1'b1, -1);
        chk(data_ready && rx_data == 8'h81, "R3 receiver rearms after reject", rx_data, 8'h81);
        rd(0, 1);

        // enable control
        send_frame(8'h77, 1'b1, 0);
        chk(data_ready == 0, "R2 disabled receiver ignores frame", data_ready, 0);
        send_frame(8'h66, 1'b1, 5);
        chk(data_ready == 0 && rx_data == 8'h81, "R2 mid-frame disable discards byte", rx_data, 8'h81);
        send_frame(8'h99, 1'b1, -1);
        chk(data_ready && rx_data == 8'h99, "R2 reenabled receiver works", rx_data, 8'h99);
        rd(0, 1);

        // framing error
        send_frame(8'h42, 1'b0, -1);
        chk(frame_err == 1 && data_ready && rx_data == 8'h42, "R8 low stop bit", frame_err, 1);
        rd(0, 1);
        chk(frame_err == 1, "R7 frame error survives lone data read", frame_err, 1);
        clear_all();
        chk(frame_err == 0, "R7 frame error cleared by sequence", frame_err, 0);

        // interrupt gating
        rx_ie = 1'b0;
        send_frame(8'hF0, 1'b1, -1);
        chk(data_ready == 1 && irq == 0, "R9 irq masked", irq, 0);
        rd(0, 1);
        rx_ie = 1'b1;
        flip[1][7] = 1'b1;
        send_frame(8'h0F, 1'b1, -1);
        rd(0, 1);
        chk(noise_err == 1 && irq == 0, "R9 noise alone raises no irq", irq, 0);
        clear_all();
        clear_flips();
        idle(2);

        run_cmp = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule